// File: doc/BRIEF.md
# Low-Level Wake-Up Qualifier

This block decides when a system in deep sleep should wake because an interrupt pin, set to sense a low level, has been pulled low. In that sleep state the main I/O clock is stopped, so edge detection is not available. The block runs entirely on a slow oscillator clock that never stops. It synchronises the pin into that domain. It accepts the low level only when two back-to-back slow-clock samples both show it. It then times a start-up delay selected by a 2-bit field and signals the end of the wake sequence.

Once a wake has been qualified, it always runs to completion. Whether an interrupt should actually be serviced is a separate matter. That is decided by checking if the pin is still low at the moment start-up ends. The result is held on a level output until the system acknowledges it. The block is armed by a sleep-enable input. After an acknowledge it goes back to idle once sleep-enable is released.

Top module: `lvl_wake_qual`

## Requirements
- R1: After reset, `wake_done` and `irq_valid` are both 0.
- R2: While `sleep_en` is low and the block is idle, a low level on `pin_n` of any length produces no `wake_done`.
- R3: A low level on `pin_n` that lasts only one clock cycle while armed does not start a wake.
- R4: `pin_n` passes through a two-flop synchroniser. A low level held for at least two cycles while armed starts a wake. `wake_done` then rises on the (L+5)-th rising edge counted from the first edge that sees the low pin, where L is the selected start-up length.
- R5: `sut_sel` selects L as follows: 0 gives 0 cycles, 1 gives 16, 2 gives 256, 3 gives 4096.
- R6: `wake_done` is high for exactly one cycle per completed wake.
- R7: `irq_valid` rises together with `wake_done` when the synchronised pin is still low at the end of start-up. It then stays high until `ack`.
- R8: If the pin returns high before start-up ends, `wake_done` still pulses but `irq_valid` stays 0.
- R9: `ack` high in a cycle clears `irq_valid` at the next edge. `ack` takes priority over setting it.
- R10: `sut_sel` is captured when the wake is qualified. Changing it during the count has no effect on the timing.
- R11: Dropping `sleep_en` during the count does not cancel the wake. After a completed wake, no new wake starts until `ack` has been seen and `sleep_en` has been low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_en | input | 1 | Arms the qualifier while high |
| pin_n | input | 1 | Raw interrupt pin, active low, asynchronous |
| sut_sel | input | 2 | Start-up length select (0/16/256/4096 cycles) |
| ack | input | 1 | Acknowledges the wake and clears `irq_valid` |
| wake_done | output | 1 | One-cycle pulse at the end of start-up |
| irq_valid | output | 1 | Interrupt should be taken; held until `ack` |

## Verification
Counting from the first rising edge that sees the pin low, the delay splits as follows. Two edges fill the synchroniser. One edge registers the earlier sample. One edge loads the counter. L edges count down, and one final edge registers `wake_done` and `irq_valid`. This gives L+5 edges in total. The bench drives every input at a falling edge and samples outputs at the following falling edge. It counts edges from the drive and requires the pulse at exactly L+5. For the level-loss case, the pin is held low for exactly two cycles, the minimum that qualifies. An `ack` is expected to clear `irq_valid` by the falling edge one cycle after it is driven.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT,
    ST_DONE,
    ST_ACKED
  } wq_state_e;
endpackage

// File: rtl/wq_rst_sync.sv
module wq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/wq_pin_sync.sv
module wq_pin_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/wq_startup_cnt.sv
module wq_startup_cnt #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load | ~zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lvl_wake_qual.sv
module lvl_wake_qual
  import wq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int SUT_CYC0    = 0,
  parameter int SUT_CYC1    = 16,
  parameter int SUT_CYC2    = 256,
  parameter int SUT_CYC3    = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_en,
  input  logic       pin_n,
  input  logic [1:0] sut_sel,
  input  logic       ack,
  output logic       wake_done,
  output logic       irq_valid
);
  localparam int MAX01   = (SUT_CYC0 > SUT_CYC1) ? SUT_CYC0 : SUT_CYC1;
  localparam int MAX23   = (SUT_CYC2 > SUT_CYC3) ? SUT_CYC2 : SUT_CYC3;
  localparam int CNT_MAX = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int CNT_W   = (CNT_MAX < 1) ? 1 : $clog2(CNT_MAX + 1);

  logic             rst_i;
  logic             pin_s;
  logic             low_s;
  logic             lo_prev_q, lo_prev_d;
  wq_state_e        st_q, st_d;
  logic             qualify;
  logic             finish;
  logic             cnt_load;
  logic             cnt_zero;
  logic [CNT_W-1:0] sut_len;
  logic             wake_d;
  logic             irq_d;

  wq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_i)
  );

  wq_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (pin_n),
    .q     (pin_s)
  );

  wq_startup_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .load     (cnt_load),
    .load_val (sut_len),
    .zero     (cnt_zero)
  );

  always_comb begin
    case (sut_sel)
      2'd0:    sut_len = CNT_W'(SUT_CYC0);
      2'd1:    sut_len = CNT_W'(SUT_CYC1);
      2'd2:    sut_len = CNT_W'(SUT_CYC2);
      default: sut_len = CNT_W'(SUT_CYC3);
    endcase
  end

  assign low_s     = ~pin_s;
  assign lo_prev_d = (st_q == ST_ARMED) & low_s;
  assign qualify   = (st_q == ST_ARMED) & sleep_en & low_s & lo_prev_q;
  assign finish    = (st_q == ST_WAIT) & cnt_zero;
  assign cnt_load  = qualify;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (sleep_en) st_d = ST_ARMED;
      ST_ARMED: begin
        if (!sleep_en)    st_d = ST_IDLE;
        else if (qualify) st_d = ST_WAIT;
      end
      ST_WAIT:  if (cnt_zero) st_d = ST_DONE;
      ST_DONE:  if (ack) st_d = sleep_en ? ST_ACKED : ST_IDLE;
      ST_ACKED: if (!sleep_en) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  assign wake_d = finish;

  always_comb begin
    if (ack)         irq_d = 1'b0;
    else if (finish) irq_d = low_s;
    else             irq_d = irq_valid;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q      <= ST_IDLE;
      lo_prev_q <= 1'b0;
      wake_done <= 1'b0;
      irq_valid <= 1'b0;
    end else begin
      st_q      <= st_d;
      lo_prev_q <= lo_prev_d;
      wake_done <= wake_d;
      irq_valid <= irq_d;
    end
  end
endmodule

// File: rtl/lwq_chk.sv
module lwq_chk
  import wq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      sleep_en,
  input logic      ack,
  input logic      wake_done,
  input logic      irq_valid,
  input wq_state_e st_q,
  input logic      lo_prev_q
);
  // R6
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> !wake_done);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !ack) |=> irq_valid);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> wake_done);

  // R9
  irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_valid);

  // R2
  armed_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED) |-> $past(sleep_en));

  // R4
  qual_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && $past(st_q) == ST_ARMED) |-> $past(lo_prev_q));
endmodule

bind lvl_wake_qual lwq_chk u_lwq_chk (
  .clk       (clk),
  .rst_n     (rst_i),
  .sleep_en  (sleep_en),
  .ack       (ack),
  .wake_done (wake_done),
  .irq_valid (irq_valid),
  .st_q      (st_q),
  .lo_prev_q (lo_prev_q)
);

// File: tb/test_lvl_wake_qual.sv
`timescale 1ns/1ps
module test_lvl_wake_qual;
  logic       clk;
  logic       rst_n;
  logic       sleep_en;
  logic       pin_n;
  logic [1:0] sut_sel;
  logic       ack;
  logic       wake_done;
  logic       irq_valid;

  int n_chk;
  int n_fail;

  lvl_wake_qual i_lvl_wake_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_en  (sleep_en),
    .pin_n     (pin_n),
    .sut_sel   (sut_sel),
    .ack       (ack),
    .wake_done (wake_done),
    .irq_valid (irq_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  function automatic int len_of(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 16;
      2'd2: return 256;
      default: return 4096;
    endcase
  endfunction

  // counts edges from the last drive; returns the edge index of wake_done or -1
  task automatic wait_wake(input int start, input int limit, output int at);
    at = -1;
    for (int i = start + 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (wake_done) begin
        at = i;
        break;
      end
    end
  endtask

  task automatic arm();
    sleep_en = 1'b1;
    cyc(3);
  endtask

  task automatic finish_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk(irq_valid == 1'b0, "R9 ack clears irq", irq_valid, 0);
    pin_n = 1'b1;
    sleep_en = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    chk(wake_done == 1'b0, "R1 reset wake_done", wake_done, 0);
    chk(irq_valid == 1'b0, "R1 reset irq_valid", irq_valid, 0);
  endtask

  task automatic t_idle_ignore();
    int at;
    sleep_en = 1'b0;
    pin_n = 1'b0;
    wait_wake(0, 40, at);
    chk(at == -1, "R2 idle ignores pin", at, -1);
    pin_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_glitch();
    int at;
    arm();
    pin_n = 1'b0;
    cyc(1);
    pin_n = 1'b1;
    wait_wake(1, 60, at);
    chk(at == -1, "R3 one-cycle low ignored", at, -1);
    sleep_en = 1'b0;
    cyc(3);
  endtask

  task automatic t_wake_hold(input logic [1:0] s);
    int at;
    sut_sel = s;
    arm();
    pin_n = 1'b0;
    wait_wake(0, 5000, at);
    chk(at == len_of(s) + 5, "R4 R5 wake timing", at, len_of(s) + 5);
    chk(irq_valid == 1'b1, "R7 irq set while held", irq_valid, 1);
    cyc(1);
    chk(wake_done == 1'b0, "R6 single pulse", wake_done, 0);
    cyc(3);
    chk(irq_valid == 1'b1, "R7 irq held until ack", irq_valid, 1);
    finish_ack();
  endtask

  task automatic t_level_lost();
    int at;
    sut_sel = 2'd1;
    arm();
    pin_n = 1'b0;
    cyc(2);
    pin_n = 1'b1;
    wait_wake(2, 200, at);
    chk(at == 21, "R8 wake completes after loss", at, 21);
    chk(irq_valid == 1'b0, "R8 irq suppressed", irq_valid, 0);
    finish_ack();
  endtask

  task automatic t_sel_late();
    int at;
    sut_sel = 2'd3;
    arm();
    pin_n = 1'b0;
    wait_wake(0, 10, at);
    sut_sel = 2'd0;
    wait_wake(10, 5000, at);
    chk(at == 4101, "R10 sel captured", at, 4101);
    finish_ack();
  endtask

  task automatic t_rearm();
    int at;
    sut_sel = 2'd2;
    arm();
    pin_n = 1'b0;
    wait_wake(0, 20, at);
    sleep_en = 1'b0;
    wait_wake(20, 1000, at);
    chk(at == 261, "R11 sleep drop does not cancel", at, 261);
    pin_n = 1'b1;
    sleep_en = 1'b1;
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    pin_n = 1'b0;
    wait_wake(0, 40, at);
    chk(at == -1, "R11 no rewake before sleep_en toggles", at, -1);
    pin_n = 1'b1;
    sleep_en = 1'b0;
    cyc(3);
    sut_sel = 2'd0;
    arm();
    pin_n = 1'b0;
    wait_wake(0, 40, at);
    chk(at == 5, "R11 rewake after toggle", at, 5);
    finish_ack();
  endtask

  initial begin
    rst_n = 1'b0;
    sleep_en = 1'b0;
    pin_n = 1'b1;
    sut_sel = 2'd0;
    ack = 1'b0;
    n_chk = 0;
    n_fail = 0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_idle_ignore();
    t_glitch();
    t_wake_hold(2'd0);
    t_wake_hold(2'd1);
    t_wake_hold(2'd2);
    t_wake_hold(2'd3);
    t_level_lost();
    t_sel_late();
    t_rearm();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule